// File: doc/BRIEF.md
# Glitch-Free System Clock Prescaler

This block derives the chip's synchronous clock from an oscillator and spreads one divided waveform to the CPU, I/O, ADC and flash clock domains. A 4-bit division code chooses the ratio. The code can be rewritten at any time without a short pulse reaching the domains. A changed ratio starts only on a falling edge of the divided clock. That edge is the point where a whole period of the old setting has just ended.

Every output is a registered level, so the block is timed from `clk_2x`, a clock at twice the oscillator rate. One output phase (high or low) lasts 2^s cycles of `clk_2x`, so a full period equals 2^s oscillator periods. The shift `s` comes from the code through one of two mappings. The `rc_src_sel` input picks the mapping used when the internal RC oscillator is the source. The divided clock can also drive a pad when a static fuse input is set. That path replaces the pin's normal output and is not blocked by reset.

A status output marks non-volatile programming as not allowed while the RC source runs at its fastest setting. There is no data stream, so no valid/ready handshake applies. All pins are plain control and status levels.

Top module: `sysclk_prescaler`

## Requirements
- R1: `clk_cpu`, `clk_io`, `clk_adc` and `clk_flash` always carry the same waveform.
- R2: With `rc_src_sel`=0, code n gives a shift of min(n,8). Each high or low phase then lasts 2^shift cycles of `clk_2x`.
- R3: With `rc_src_sel`=1, code 15 gives shift 0. Codes 0 to 6 give shift n+1, and codes 7 to 14 give shift 8.
- R4: After a code change, every output phase lasts either the old or the new length. At most one full old-length phase follows the change before all phases take the new length. A new shift is applied only on a falling edge of the divided clock.
- R5: While `rst_n` is low, the code register is 0 and the divided clock is low. After release the normal mapping gives phases of 1 cycle.
- R6: With `clkout_fuse`=1, `pin_clkout` equals the divided clock, also during reset. With `clkout_fuse`=0, it equals `pin_gpio_out`.
- R7: `nvm_prog_block` is 1 exactly when `rc_src_sel`=1 and the stored code is 15.
- R8: The code register loads `code_wr_data` on a clock edge with `code_wr_en`=1. `code_wr_data` has no effect while `code_wr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x | input | 1 | Timing clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_wr_en | input | 1 | Write strobe for the division code |
| code_wr_data | input | 4 | New division code |
| rc_src_sel | input | 1 | Internal RC source selected; picks the RC mapping |
| clkout_fuse | input | 1 | Static clock-out enable |
| pin_gpio_out | input | 1 | Normal pin value when clock-out is off |
| clk_cpu | output | 1 | Divided clock, CPU domain |
| clk_io | output | 1 | Divided clock, I/O domain |
| clk_adc | output | 1 | Divided clock, ADC domain |
| clk_flash | output | 1 | Divided clock, flash domain |
| pin_clkout | output | 1 | Pad drive: divided clock or normal pin value |
| nvm_prog_block | output | 1 | Non-volatile programming not allowed |

## Verification
A write takes one `clk_2x` edge to reach the code register, so `nvm_prog_block` is sampled on the falling edge that follows. The new phase length does not appear until the next falling edge of the divided clock. The bench therefore does not sample at a fixed cycle. It measures whole phases by counting falling edges of `clk_2x` between level changes. It throws away the partial phase in which the write landed, then checks the following six phases against the old and new lengths. The pad and domain outputs are combinational from the divided register, so they are compared in the same sample.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  localparam int CODE_W    = 4;
  localparam int MAX_SHIFT = 8;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int CNT_W     = MAX_SHIFT;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [SHIFT_W-1:0] shift_t;
endpackage

// File: rtl/presc_code_map.sv
module presc_code_map
  import prescaler_pkg::*;
(
  input  code_t  code,
  input  logic   rc_mode,
  output shift_t shift
);
  localparam code_t ALL_ONES = '1;

  always_comb begin
    if (rc_mode) begin
      // RC source: top code is the fastest point, others sit one step slower
      if (code == ALL_ONES)
        shift = '0;
      else if (int'(code) >= MAX_SHIFT - 1)
        shift = shift_t'(MAX_SHIFT);
      else
        shift = shift_t'(int'(code) + 1);
    end else begin
      if (int'(code) > MAX_SHIFT)
        shift = shift_t'(MAX_SHIFT);
      else
        shift = shift_t'(code);
    end
  end
endmodule

// File: rtl/presc_div_core.sv
module presc_div_core
  import prescaler_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  shift_t target_shift,
  output logic   div_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  shift_t           shift_q;
  logic             wrap;

  // phase length 2^shift; at full shift the one-hot wraps to zero and the
  // subtraction yields all ones, which is the right terminal count
  always_comb begin
    half_m1 = ({{(CNT_W-1){1'b0}}, 1'b1} << shift_q) - {{(CNT_W-1){1'b0}}, 1'b1};
    wrap    = (cnt_q == half_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= 1'b0;
      shift_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      div_q <= ~div_q;
      // safe point: a high phase ends here, a whole old period is done
      if (div_q) shift_q <= target_shift;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: the active shift moves only together with a falling output edge
  p_shift_at_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_q != $past(shift_q)) |-> ($past(div_q) && !div_q));

  // R4: mid-phase counting never disturbs the output level
  p_no_midphase_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(div_q));

  // R5: output held low throughout reset
  p_low_in_reset_r5: assert property (@(posedge clk)
    !rst_n |-> !div_q);
endmodule

// File: rtl/presc_pad_mux.sv
module presc_pad_mux (
  input  logic fuse,
  input  logic div_clk,
  input  logic gpio_val,
  output logic pad
);
  // deliberately not gated by reset: the fuse override holds at all times
  always_comb pad = fuse ? div_clk : gpio_val;
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import prescaler_pkg::*;
(
  input  logic              clk_2x,
  input  logic              rst_n,
  input  logic              code_wr_en,
  input  logic [CODE_W-1:0] code_wr_data,
  input  logic              rc_src_sel,
  input  logic              clkout_fuse,
  input  logic              pin_gpio_out,
  output logic              clk_cpu,
  output logic              clk_io,
  output logic              clk_adc,
  output logic              clk_flash,
  output logic              pin_clkout,
  output logic              nvm_prog_block
);
  code_t  code_q;
  shift_t target_shift;
  logic   div_clk;

  always_ff @(posedge clk_2x or negedge rst_n) begin
    if (!rst_n)          code_q <= '0;
    else if (code_wr_en) code_q <= code_wr_data;
  end

  presc_code_map u_map (
    .code    (code_q),
    .rc_mode (rc_src_sel),
    .shift   (target_shift)
  );

  presc_div_core u_core (
    .clk          (clk_2x),
    .rst_n        (rst_n),
    .target_shift (target_shift),
    .div_q        (div_clk)
  );

  presc_pad_mux u_pad (
    .fuse     (clkout_fuse),
    .div_clk  (div_clk),
    .gpio_val (pin_gpio_out),
    .pad      (pin_clkout)
  );

  // R1: one waveform fans out to every synchronous domain
  always_comb begin
    clk_cpu   = div_clk;
    clk_io    = div_clk;
    clk_adc   = div_clk;
    clk_flash = div_clk;
  end

  always_comb nvm_prog_block = rc_src_sel && (code_q == '1);

  // R8: a strobed write lands in the register on the next edge
  p_code_load_r8: assert property (@(posedge clk_2x) disable iff (!rst_n)
    code_wr_en |=> (code_q == $past(code_wr_data)));

  // R8: without a strobe the stored code holds
  p_code_hold_r8: assert property (@(posedge clk_2x) disable iff (!rst_n)
    !code_wr_en |=> $stable(code_q));
endmodule

// File: tb/sim_sysclk_prescaler.sv
`timescale 1ns/1ps
module sim_sysclk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] wr_data;
  logic       rc;
  logic       fuse;
  logic       gpio;
  logic       c_cpu, c_io, c_adc, c_flash, pad, nvm;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sysclk_prescaler u0 (
    .clk_2x(clk), .rst_n(rst_n), .code_wr_en(wr_en), .code_wr_data(wr_data),
    .rc_src_sel(rc), .clkout_fuse(fuse), .pin_gpio_out(gpio),
    .clk_cpu(c_cpu), .clk_io(c_io), .clk_adc(c_adc), .clk_flash(c_flash),
    .pin_clkout(pad), .nvm_prog_block(nvm)
  );

  function automatic int shift_norm(int c);
    return (c > 8) ? 8 : c;
  endfunction

  function automatic int shift_rc(int c);
    if (c == 15) return 0;
    return (c >= 7) ? 8 : c + 1;
  endfunction

  function automatic int phase_len(int rcm, int c);
    return 1 << (rcm != 0 ? shift_rc(c) : shift_norm(c));
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // run length of the current level, sampled on falling clock edges;
  // leaves the bench on the first sample of the next phase
  task automatic get_phase(output int len);
    logic lvl;
    lvl = c_cpu;
    len = 1;
    forever begin
      @(negedge clk);
      if (c_cpu !== lvl) break;
      len++;
    end
  endtask

  task automatic write_code(input int c);
    wr_en   = 1'b1;
    wr_data = 4'(c);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic change_and_check(input int old_len, input int new_len, input string req);
    int len;
    int bad;
    get_phase(len);  // partial phase in flight, discarded
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      get_phase(len);
      if (len != old_len && len != new_len) bad = len;
      if (k >= 2) check(req, len, new_len);
    end
    check("R4 no foreign phase length", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 4'd0; rc = 1'b0; fuse = 1'b1; gpio = 1'b1;
    repeat (3) @(negedge clk);
    // R5 / R6: in reset output low, fuse override still drives the pad
    check("R5 low in reset", int'(c_cpu), 0);
    check("R6 pad in reset", int'(pad), 0);
    fuse = 1'b0;
    #0.1;
    check("R6 gpio in reset", int'(pad), 1);
    fuse = 1'b1;
    check("R7 flag after reset", int'(nvm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    begin
      int len;
      get_phase(len);
      for (int k = 0; k < 4; k++) begin get_phase(len); check("R5 code 0 after reset", len, 1); end
    end

    // R2 sweep over normal mapping with R4 transition checks
    begin
      int old;
      old = phase_len(0, 0);
      for (int c = 0; c < 16; c++) begin
        write_code(c);
        change_and_check(old, phase_len(0, c), "R2");
        old = phase_len(0, c);
      end
      // R7: code 15 on normal source does not block
      check("R7 normal src code 15", int'(nvm), 0);
      write_code(0);
      change_and_check(old, 1, "R4 back to fastest");
    end

    // switch mapping at code 0, let it settle
    rc = 1'b1;
    begin
      int len;
      for (int k = 0; k < 8; k++) get_phase(len);
    end

    // R3 sweep over RC mapping
    begin
      int old;
      old = phase_len(1, 0);
      for (int c = 0; c < 16; c++) begin
        write_code(c);
        change_and_check(old, phase_len(1, c), "R3");
        old = phase_len(1, c);
        if (c == 14) check("R7 rc code 14", int'(nvm), 0);
        if (c == 15) check("R7 rc code 15", int'(nvm), 1);
      end
      // R8: data without strobe has no effect on phases
      wr_data = 4'd3;
      begin
        int len;
        get_phase(len);
        for (int k = 0; k < 4; k++) begin get_phase(len); check("R8 ignored data", len, 1); end
      end
      check("R8 flag unchanged", int'(nvm), 1);
      // R4 large step slow -> fast and back
      write_code(8);
      change_and_check(1, 256, "R4 step down");
      write_code(15);
      change_and_check(256, 1, "R4 step up");
    end

    // R1 / R6: domains identical and pad follows divided clock with fuse set
    begin
      int mism;
      int gmis;
      mism = 0;
      gmis = 0;
      rc = 1'b0;
      write_code(1);
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (c_io !== c_cpu || c_adc !== c_cpu || c_flash !== c_cpu) mism++;
        if (pad !== c_cpu) mism++;
      end
      check("R1 R6 domains and pad match", mism, 0);
      fuse = 1'b0;
      for (int k = 0; k < 10; k++) begin
        gpio = 1'(k & 1);
        @(negedge clk);
        if (pad !== gpio) gmis++;
      end
      check("R6 gpio passthrough", gmis, 0);
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule